// File: doc/BRIEF.md
# Timed Multi-Phase Level Sequencer

This block drives one output bit through a repeating list of timed phases. Each phase has its own length in clock cycles and its own output level. When the last phase ends, the list starts again from the first. A single wide cycle counter and a phase index do all the timing. Each phase is therefore entered exactly once per pass, whatever the relative lengths of its neighbours.

The schedule is fixed by parameters. A packed vector holds one duration per phase, with entry 0 in the least significant slot. A second vector holds one level per phase, with bit i giving the level of phase i.

By default the counter and the durations are 48 bits wide. At a 250 MHz clock this reaches delays of hundreds of hours. The default list has five phases at 250,000,000 cycles per second:
- phase 0: low for 40 s
- phase 1: high for 8 s
- phase 2: low for 40 s
- phase 3: high for 8 s
- phase 4: low for 40 s

An enable input freezes the whole sequence while it is low.

Top module: `phase_seq`

## Requirements
- R1: While reset is asserted, and immediately after it is released, the phase index is 0, the output equals the level of phase 0 (low in the default table), and the phase-end strobe is low.
- R2: A phase with a nonzero duration D stays current for exactly D enabled clock cycles. The index then advances by one.
- R3: After the last phase (index NUM_PHASES-1) ends, the index returns to 0 and the schedule repeats.
- R4: The output is registered. It always equals the level bit of the current phase index, and it changes on the same clock edge as the index.
- R5: The phase-end strobe is high only on the last enabled cycle of each phase, for one cycle per phase visit.
- R6: While enable is low, the index, the internal counter and the output hold their values, and the strobe stays low. After enable returns, the phase resumes with its remaining cycles.
- R7: A phase whose duration entry is 0 lasts exactly one enabled cycle. It never stalls the sequence.
- R8: With default parameters the counter and duration entries are 48 bits wide. The schedule is 10,000,000,000 / 2,000,000,000 / 10,000,000,000 / 2,000,000,000 / 10,000,000,000 cycles at levels low/high/low/high/low, and the output is low and in phase 0 for the first 40 s after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Advance enable; low freezes the sequence |
| seq_out | output | 1 | Sequenced level, registered |
| phase_idx | output | IDX_W | Index of the current phase |
| phase_end | output | 1 | High on the last cycle of each phase |

## Verification
The main instance is built with four phases of lengths 3, 0, 2 and 5 cycles at levels low, high, high, low. It keeps the full 48-bit counter width. These short lengths let many complete passes, wraps, zero-length phases and enable gaps mid-phase fit in a short run. A second instance keeps every default. It confirms that the first, multi-billion-cycle phase holds the output low and the index at 0 across the whole run, which exercises the wide duration constants without truncation.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int unsigned SEQ_CNT_W = 48;
  localparam int unsigned SEQ_PHASES = 5;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/seq_phase_table.sv
module seq_phase_table #(
  parameter int unsigned NUM_PHASES = 5,
  parameter int unsigned CNT_W      = 48,
  parameter logic [NUM_PHASES*CNT_W-1:0] PHASE_DUR = '0,
  localparam int unsigned IDX_W = seq_pkg::idx_width(NUM_PHASES)
) (
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] last_cnt
);
  logic [CNT_W-1:0] last_tab [NUM_PHASES];

  generate
    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_entry
      localparam logic [CNT_W-1:0] RAW = PHASE_DUR[g*CNT_W +: CNT_W];
      assign last_tab[g] = (RAW == '0) ? '0 : RAW - 1'b1;
    end
  endgenerate

  always_comb begin
    last_cnt = last_tab[0];
    for (int i = 0; i < NUM_PHASES; i++) begin
      if (rd_idx == IDX_W'(i)) last_cnt = last_tab[i];
    end
  end
endmodule

// File: rtl/seq_cycle_counter.sv
module seq_cycle_counter #(
  parameter int unsigned CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] last_cnt,
  output logic             at_last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign at_last = (cnt_q == last_cnt);

  always_comb begin
    cnt_d = cnt_q;
    if (en) cnt_d = at_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_cnt); // R7
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/seq_phase_index.sv
module seq_phase_index #(
  parameter int unsigned NUM_PHASES = 5,
  localparam int unsigned IDX_W = seq_pkg::idx_width(NUM_PHASES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] idx_q,
  output logic [IDX_W-1:0] idx_d
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PHASES - 1);

  always_comb begin
    idx_d = idx_q;
    if (adv) idx_d = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) < NUM_PHASES); // R2
  AST_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (idx_q == (($past(idx_q) == LAST_IDX) ? '0 : $past(idx_q) + 1'b1))); // R3
endmodule

// File: rtl/phase_seq.sv
module phase_seq #(
  parameter int unsigned NUM_PHASES = seq_pkg::SEQ_PHASES,
  parameter int unsigned CNT_W      = seq_pkg::SEQ_CNT_W,
  parameter logic [NUM_PHASES*CNT_W-1:0] PHASE_DUR = {
    48'd10_000_000_000, 48'd2_000_000_000, 48'd10_000_000_000,
    48'd2_000_000_000, 48'd10_000_000_000},
  parameter logic [NUM_PHASES-1:0] PHASE_LVL = 5'b01010,
  localparam int unsigned IDX_W = seq_pkg::idx_width(NUM_PHASES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic             seq_out,
  output logic [IDX_W-1:0] phase_idx,
  output logic             phase_end
);
  logic [CNT_W-1:0] last_cnt;
  logic             at_last;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             out_q, out_d;

  seq_phase_table #(
    .NUM_PHASES(NUM_PHASES), .CNT_W(CNT_W), .PHASE_DUR(PHASE_DUR)
  ) u_table (
    .rd_idx(idx_q), .last_cnt(last_cnt)
  );

  seq_cycle_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .en(en), .last_cnt(last_cnt), .at_last(at_last)
  );

  assign phase_end = en & at_last;

  seq_phase_index #(.NUM_PHASES(NUM_PHASES)) u_index (
    .clk(clk), .rst_n(rst_n), .adv(phase_end), .idx_q(idx_q), .idx_d(idx_d)
  );

  always_comb begin
    out_d = out_q;
    if (en) out_d = PHASE_LVL[idx_d];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= PHASE_LVL[0];
    else        out_q <= out_d;
  end

  assign seq_out   = out_q;
  assign phase_idx = idx_q;

  AST_OUT_MATCHES_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_out == PHASE_LVL[phase_idx]); // R4
  AST_END_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    phase_end |-> en); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(phase_idx) && $stable(seq_out))); // R6
  AST_IDX_MOVES_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_end |=> $stable(phase_idx)); // R5
endmodule

// File: tb/test_phase_seq.sv
`timescale 1ns/1ps
module test_phase_seq;
  localparam int N = 4;
  localparam int W = 48;
  localparam logic [N*W-1:0] DUR = {48'd5, 48'd2, 48'd0, 48'd3};
  localparam logic [N-1:0]   LVL = 4'b0110;
  localparam int BDUR [N] = '{3, 0, 2, 5};

  typedef struct {
    logic [1:0] idx;
    logic       out;
    logic       stb;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic       seq_out, phase_end;
  logic [1:0] phase_idx;
  logic       d_out, d_end;
  logic [2:0] d_idx;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  item_t sb[$];

  int m_idx = 0;
  int m_cnt = 0;
  bit m_wrapped = 0;

  always #2 clk = ~clk;

  phase_seq #(.NUM_PHASES(N), .CNT_W(W), .PHASE_DUR(DUR), .PHASE_LVL(LVL)) i_phase_seq (
    .clk(clk), .rst_n(rst_n), .en(en),
    .seq_out(seq_out), .phase_idx(phase_idx), .phase_end(phase_end));

  phase_seq i_phase_seq_dflt (
    .clk(clk), .rst_n(rst_n), .en(1'b1),
    .seq_out(d_out), .phase_idx(d_idx), .phase_end(d_end));

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: applies enable for one cycle and pushes the expected outputs
  task automatic drive(input bit e);
    item_t it;
    int last;
    @(negedge clk);
    en = e;
    last = (BDUR[m_idx] == 0) ? 0 : BDUR[m_idx] - 1;
    it.idx = 2'(m_idx);
    it.out = LVL[m_idx];
    it.stb = e && (m_cnt == last);
    if (!e) it.tag = "R6";
    else if (m_wrapped) it.tag = "R3";
    else if (BDUR[m_idx] == 0) it.tag = "R7";
    else it.tag = "R2";
    sb.push_back(it);
    m_wrapped = 0;
    if (e) begin
      if (m_cnt == last) begin
        m_cnt = 0;
        if (m_idx == N - 1) begin
          m_idx = 0;
          m_wrapped = 1;
        end else m_idx++;
      end else m_cnt++;
    end
  endtask

  // monitor: pops and compares once per cycle, away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(phase_idx == it.idx, it.tag, "phase_idx", phase_idx, it.idx);
        check(seq_out == it.out, "R4", "seq_out", seq_out, it.out);
        check(phase_end == it.stb, "R5", "phase_end", phase_end, it.stb);
      end
      if (rst_n) begin
        check(d_out == 1'b0 && d_idx == 3'd0 && d_end == 1'b0, "R8",
              "default instance out/idx/end", {d_out, d_idx, d_end}, 0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(phase_idx == 2'd0, "R1", "reset phase_idx", phase_idx, 0);
    check(seq_out == 1'b0, "R1", "reset seq_out", seq_out, 0);
    check(phase_end == 1'b0, "R1", "reset phase_end", phase_end, 0);
    check(d_out == 1'b0, "R1", "reset default seq_out", d_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 30; i++) drive(1'b1);
    for (int i = 0; i < 7; i++) drive(1'b0);
    for (int i = 0; i < 21; i++) drive(1'b1);
    for (int i = 0; i < 24; i++) drive(i[0]);
    for (int i = 0; i < 12; i++) drive(i % 3 != 0);
    for (int i = 0; i < 40; i++) drive(1'b1);
    @(negedge clk);
    en = 1'b0;
    #2;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule